// File: doc/BRIEF.md
# 64-bit Compare Timer with Periodic Reload

This block is a free-running 64-bit up-counter with one 64-bit compare value, a sticky event flag and a level interrupt. Software programs it through a single-cycle register port of 32-bit words. Because the counter and the compare value are each twice the port width, each one sits in a pair of word registers. The counter advances by one on every clock while its run bit is set.

A compare hit occurs when the counter is greater than or equal to the compare value. A hit only counts while compare is enabled. It sets the event flag, which stays set until software writes a one to it. The interrupt line follows the flag, gated by the interrupt enable and the compare enable. In periodic mode each hit adds a 32-bit step to the compare value, so a steady train of events needs no software reload. An arming bit makes sure that one crossing sets the flag only once.

Register word offsets (byte address): counter low 0x00, counter high 0x04, control 0x08, status 0x0C, compare low 0x10, compare high 0x14, step 0x18. Control bits: 0 run, 1 compare enable, 2 interrupt enable, 3 periodic reload. Status bit 0 is the event flag.

Top module: `cmp_timer64`

## Requirements
- R1: After reset the control, status, counter, compare and step registers are all zero, and `irqOut` is low.
- R2: While control bit 0 (run) is 1, the counter increases by exactly one at every clock edge. While it is 0, the counter holds its value.
- R3: Writes to the counter words at 0x00 and 0x04 load that 32-bit word only while run is 0. While run is 1 such writes are ignored and counting carries on.
- R4: While control bit 1 (compare enable) is 1 and the 64-bit counter is greater than or equal to the 64-bit compare value, a hit occurs. Status bit 0 (0x0C) reads 1 from the clock edge that follows the hit cycle.
- R5: Writing 1 to status bit 0 clears the flag, and writing 0 there has no effect. If a hit and a clearing write fall in the same cycle, the flag stays set.
- R6: `irqOut` is high exactly when the flag, control bit 2 (interrupt enable) and control bit 1 are all 1. It is a level signal with no delay from those registers.
- R7: While compare enable is 0, writes to the compare words (0x10, 0x14) never set the flag.
- R8: Outside periodic mode, one crossing sets the flag once. After it is cleared, the flag sets again only after a write to a compare word, or after the counter has been below the compare value and reaches it again.
- R9: While control bit 3 (periodic) is 1, each hit adds the 32-bit step register (0x18) to the compare value, modulo 2^64. A compare-word write in the same cycle takes priority over this reload.
- R10: The counter wraps from all ones to zero.
- R11: Reads of unused offsets (0x1C) return zero. The control register reads back only its bits 3:0, and writes to bits above 3 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle register write strobe |
| addr | input | ADDR_W (5) | Byte address of the register word; bits 1:0 are ignored |
| wrData | input | DATA_W (32) | Write data |
| rdData | output | DATA_W (32) | Read data for `addr`, combinational from the registers |
| irqOut | output | 1 | Level interrupt request |

## Verification
A register write takes effect at the clock edge that samples its strobe, and read data and `irqOut` follow the registers with no further delay. A hit that exists during a cycle shows in the flag and in the reloaded compare value one edge later. A counter that is started at one edge and stopped at a later edge has advanced by the number of edges from the start edge to the stop edge, inclusive of the stop edge and exclusive of the start edge. The bench drives every write for exactly one edge and spends idle edges only by explicit count. It reads in the low clock phase, so each expected value is the count of edges since the stimulus worked through by hand.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  // Word indices (byte offset / 4) of the register file.
  localparam int unsigned WIX_CNT_LO = 0;
  localparam int unsigned WIX_CNT_HI = 1;
  localparam int unsigned WIX_CTRL   = 2;
  localparam int unsigned WIX_STAT   = 3;
  localparam int unsigned WIX_CMP_LO = 4;
  localparam int unsigned WIX_CMP_HI = 5;
  localparam int unsigned WIX_STEP   = 6;

  // Control register bit positions.
  localparam int unsigned CTL_RUN  = 0;
  localparam int unsigned CTL_CMP  = 1;
  localparam int unsigned CTL_IRQ  = 2;
  localparam int unsigned CTL_AUTO = 3;
  localparam int unsigned CTL_W    = 4;

  // Strobes and mode levels passed from control to datapath.
  typedef struct packed {
    logic cntLoWr;
    logic cntHiWr;
    logic cmpLoWr;
    logic cmpHiWr;
    logic stepWr;
    logic runEn;
    logic cmpEn;
    logic autoEn;
  } dpCtl_t;

endpackage

// File: rtl/cmp_timer_dp.sv
module cmp_timer_dp
  import cmp_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtl_t              ctl,
  input  logic [DATA_W-1:0]   wrData,
  output logic [2*DATA_W-1:0] cntVal,
  output logic [2*DATA_W-1:0] cmpVal,
  output logic [DATA_W-1:0]   stepVal,
  output logic                fire
);

  localparam int CNT_W  = 2 * DATA_W;
  localparam int NWORDS = CNT_W / DATA_W;

  logic [CNT_W-1:0]                cntQ;
  logic [CNT_W-1:0]                cmpQ;
  logic [CNT_W-1:0]                cmpSum;
  logic [DATA_W-1:0]               stepQ;
  logic                            armedQ;
  logic                            geNow;
  logic                            reload;
  logic [NWORDS-1:0]               cntWordWr;
  logic [NWORDS-1:0]               cmpWordWr;
  logic [NWORDS-1:0]               carryIn;
  logic [NWORDS-1:0][DATA_W-1:0]   cntNext;
  logic [NWORDS-1:0][DATA_W-1:0]   cmpNext;

  assign cntWordWr = {ctl.cntHiWr, ctl.cntLoWr};
  assign cmpWordWr = {ctl.cmpHiWr, ctl.cmpLoWr};

  assign cmpSum = cmpQ + CNT_W'(stepQ);
  assign geNow  = (cntQ >= cmpQ);
  assign fire   = ctl.cmpEn && armedQ && geNow;
  assign reload = fire && ctl.autoEn;

  // Per-word next-state: a word increments when every lower word is all ones.
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    localparam int LO = w * DATA_W;
    if (w == 0) begin : g_lsw
      assign carryIn[w] = ctl.runEn;
    end else begin : g_msw
      assign carryIn[w] = ctl.runEn && (&cntQ[LO-1:0]);
    end

    always_comb begin
      cntNext[w] = cntQ[LO +: DATA_W];
      if (carryIn[w]) begin
        cntNext[w] = cntQ[LO +: DATA_W] + 1'b1;
      end else if (!ctl.runEn && cntWordWr[w]) begin
        cntNext[w] = wrData;
      end
    end

    always_comb begin
      cmpNext[w] = cmpQ[LO +: DATA_W];
      if (cmpWordWr[w]) begin
        cmpNext[w] = wrData;
      end else if (reload) begin
        cmpNext[w] = cmpSum[LO +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      cmpQ  <= '0;
      stepQ <= '0;
    end else begin
      cntQ <= cntNext;
      cmpQ <= cmpNext;
      if (ctl.stepWr) begin
        stepQ <= wrData;
      end
    end
  end

  // Arming: one crossing fires once unless the compare value moves.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armedQ <= 1'b1;
    end else if (|cmpWordWr) begin
      armedQ <= 1'b1;
    end else if (fire) begin
      armedQ <= ctl.autoEn;
    end else if (!geNow) begin
      armedQ <= 1'b1;
    end
  end

  assign cntVal  = cntQ;
  assign cmpVal  = cmpQ;
  assign stepVal = stepQ;

  // R2
  cnt_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.runEn |=> (cntQ == $past(cntQ) + 1'b1));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.runEn && !(|cntWordWr)) |=> $stable(cntQ));

  // R3
  run_load_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.runEn && (|cntWordWr)) |=> (cntQ == $past(cntQ) + 1'b1));

  // R10
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.runEn && (&cntQ)) |=> (cntQ == '0));

  // R9
  auto_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && ctl.autoEn && !(|cmpWordWr))
      |=> (cmpQ == $past(cmpQ) + CNT_W'($past(stepQ))));

  // R8
  single_fire_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fire && !ctl.autoEn && !(|cmpWordWr)) |=> !fire);

endmodule

// File: rtl/cmp_timer_ctrl.sv
module cmp_timer_ctrl
  import cmp_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                fire,
  input  logic [2*DATA_W-1:0] cntVal,
  input  logic [2*DATA_W-1:0] cmpVal,
  input  logic [DATA_W-1:0]   stepVal,
  output dpCtl_t              dpCtl,
  output logic [DATA_W-1:0]   rdData,
  output logic                irqOut
);

  localparam int IDX_W = ADDR_W - 2;
  localparam int CNT_W = 2 * DATA_W;

  logic [IDX_W-1:0]  idx;
  logic [CTL_W-1:0]  ctlQ;
  logic              flagQ;
  logic              ctlWr;
  logic              stsWr;

  assign idx   = addr[ADDR_W-1:2];
  assign ctlWr = wrEn && (idx == IDX_W'(WIX_CTRL));
  assign stsWr = wrEn && (idx == IDX_W'(WIX_STAT));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= '0;
    end else if (ctlWr) begin
      ctlQ <= wrData[CTL_W-1:0];
    end
  end

  // A hit in the same cycle as a clearing write wins.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (fire) begin
      flagQ <= 1'b1;
    end else if (stsWr && wrData[0]) begin
      flagQ <= 1'b0;
    end
  end

  always_comb begin
    dpCtl         = '0;
    dpCtl.cntLoWr = wrEn && (idx == IDX_W'(WIX_CNT_LO));
    dpCtl.cntHiWr = wrEn && (idx == IDX_W'(WIX_CNT_HI));
    dpCtl.cmpLoWr = wrEn && (idx == IDX_W'(WIX_CMP_LO));
    dpCtl.cmpHiWr = wrEn && (idx == IDX_W'(WIX_CMP_HI));
    dpCtl.stepWr  = wrEn && (idx == IDX_W'(WIX_STEP));
    dpCtl.runEn   = ctlQ[CTL_RUN];
    dpCtl.cmpEn   = ctlQ[CTL_CMP];
    dpCtl.autoEn  = ctlQ[CTL_AUTO];
  end

  always_comb begin
    rdData = '0;
    case (idx)
      IDX_W'(WIX_CNT_LO): rdData = cntVal[DATA_W-1:0];
      IDX_W'(WIX_CNT_HI): rdData = cntVal[CNT_W-1:DATA_W];
      IDX_W'(WIX_CTRL):   rdData = DATA_W'(ctlQ);
      IDX_W'(WIX_STAT):   rdData = DATA_W'(flagQ);
      IDX_W'(WIX_CMP_LO): rdData = cmpVal[DATA_W-1:0];
      IDX_W'(WIX_CMP_HI): rdData = cmpVal[CNT_W-1:DATA_W];
      IDX_W'(WIX_STEP):   rdData = stepVal;
      default:            rdData = '0;
    endcase
  end

  assign irqOut = flagQ && ctlQ[CTL_IRQ] && ctlQ[CTL_CMP];

  // R4
  flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(fire));

  // R7
  cmp_off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctlQ[CTL_CMP] |=> !$rose(flagQ));

  // R5
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsWr && wrData[0] && !fire) |=> !flagQ);

  // R5
  zero_write_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stsWr && !wrData[0] && flagQ) |=> flagQ);

  // R6
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !fire && !(stsWr && wrData[0]) && !ctlWr) |=> irqOut);

endmodule

// File: rtl/cmp_timer64.sv
module cmp_timer64
  import cmp_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut
);

  localparam int CNT_W = 2 * DATA_W;

  dpCtl_t             dpCtl;
  logic               fire;
  logic [CNT_W-1:0]   cntVal;
  logic [CNT_W-1:0]   cmpVal;
  logic [DATA_W-1:0]  stepVal;

  cmp_timer_ctrl #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .fire    (fire),
    .cntVal  (cntVal),
    .cmpVal  (cmpVal),
    .stepVal (stepVal),
    .dpCtl   (dpCtl),
    .rdData  (rdData),
    .irqOut  (irqOut)
  );

  cmp_timer_dp #(
    .DATA_W (DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (dpCtl),
    .wrData  (wrData),
    .cntVal  (cntVal),
    .cmpVal  (cmpVal),
    .stepVal (stepVal),
    .fire    (fire)
  );

endmodule

// File: tb/tb_cmp_timer64.sv
`timescale 1ns/100ps
module tb_cmp_timer64;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  localparam logic [1:0] OP_W = 2'd0;  // write adr <= dat
  localparam logic [1:0] OP_R = 2'd1;  // read adr, compare with exp
  localparam logic [1:0] OP_I = 2'd2;  // idle exp clock edges
  localparam logic [1:0] OP_Q = 2'd3;  // compare irqOut with exp[0]

  localparam logic [4:0] A_CLO = 5'h00;
  localparam logic [4:0] A_CHI = 5'h04;
  localparam logic [4:0] A_CTL = 5'h08;
  localparam logic [4:0] A_STS = 5'h0C;
  localparam logic [4:0] A_MLO = 5'h10;
  localparam logic [4:0] A_MHI = 5'h14;
  localparam logic [4:0] A_STP = 5'h18;
  localparam logic [4:0] A_NUL = 5'h1C;

  typedef struct packed {
    logic [1:0]  op;
    logic [4:0]  adr;
    logic [31:0] dat;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 89;
  localparam vec_t VECS [NV] = '{
    // R1 reset state
    '{OP_R, A_CTL, 32'h0, 32'h0, 4'd1},
    '{OP_R, A_STS, 32'h0, 32'h0, 4'd1},
    '{OP_R, A_CLO, 32'h0, 32'h0, 4'd1},
    '{OP_R, A_CHI, 32'h0, 32'h0, 4'd1},
    '{OP_Q, A_CTL, 32'h0, 32'h0, 4'd1},
    // R3 load while stopped
    '{OP_W, A_CLO, 32'hFFFFFFFE, 32'h0, 4'd3},
    '{OP_W, A_CHI, 32'hFFFFFFFF, 32'h0, 4'd3},
    '{OP_R, A_CLO, 32'h0, 32'hFFFFFFFE, 4'd3},
    '{OP_R, A_CHI, 32'h0, 32'hFFFFFFFF, 4'd3},
    // R2 run for 3 edges, R10 wrap to 1
    '{OP_W, A_CTL, 32'h1, 32'h0, 4'd2},
    '{OP_I, A_CTL, 32'h0, 32'd2, 4'd2},
    '{OP_W, A_CTL, 32'h0, 32'h0, 4'd2},
    '{OP_R, A_CLO, 32'h0, 32'h1, 4'd10},
    '{OP_R, A_CHI, 32'h0, 32'h0, 4'd10},
    '{OP_I, A_CTL, 32'h0, 32'd3, 4'd2},
    '{OP_R, A_CLO, 32'h0, 32'h1, 4'd2},
    // R3 load ignored while running
    '{OP_W, A_CTL, 32'h1, 32'h0, 4'd3},
    '{OP_W, A_CLO, 32'h55, 32'h0, 4'd3},
    '{OP_W, A_CTL, 32'h0, 32'h0, 4'd3},
    '{OP_R, A_CLO, 32'h0, 32'h3, 4'd3},
    // R11 control width, unused offset
    '{OP_W, A_CTL, 32'hFFFFFFF0, 32'h0, 4'd11},
    '{OP_R, A_CTL, 32'h0, 32'h0, 4'd11},
    '{OP_R, A_NUL, 32'h0, 32'h0, 4'd11},
    '{OP_W, A_STP, 32'hABCD1234, 32'h0, 4'd9},
    '{OP_R, A_STP, 32'h0, 32'hABCD1234, 4'd9},
    // R7 compare writes while compare disabled
    '{OP_W, A_MLO, 32'h2, 32'h0, 4'd7},
    '{OP_W, A_MHI, 32'h0, 32'h0, 4'd7},
    '{OP_I, A_CTL, 32'h0, 32'd2, 4'd7},
    '{OP_R, A_STS, 32'h0, 32'h0, 4'd7},
    // R4 greater-or-equal hit (count 3, compare 2)
    '{OP_W, A_CTL, 32'h2, 32'h0, 4'd4},
    '{OP_I, A_CTL, 32'h0, 32'd1, 4'd4},
    '{OP_R, A_STS, 32'h0, 32'h1, 4'd4},
    // R6 interrupt gating
    '{OP_Q, A_CTL, 32'h0, 32'h0, 4'd6},
    '{OP_W, A_CTL, 32'h6, 32'h0, 4'd6},
    '{OP_Q, A_CTL, 32'h0, 32'h1, 4'd6},
    '{OP_W, A_CTL, 32'h4, 32'h0, 4'd6},
    '{OP_Q, A_CTL, 32'h0, 32'h0, 4'd6},
    '{OP_W, A_CTL, 32'h6, 32'h0, 4'd6},
    // R5 write-one-to-clear
    '{OP_W, A_STS, 32'h0, 32'h0, 4'd5},
    '{OP_R, A_STS, 32'h0, 32'h1, 4'd5},
    '{OP_W, A_STS, 32'h1, 32'h0, 4'd5},
    '{OP_R, A_STS, 32'h0, 32'h0, 4'd5},
    '{OP_Q, A_CTL, 32'h0, 32'h0, 4'd6},
    // R8 no second set for the same crossing
    '{OP_I, A_CTL, 32'h0, 32'd3, 4'd8},
    '{OP_R, A_STS, 32'h0, 32'h0, 4'd8},
    '{OP_W, A_MLO, 32'h3, 32'h0, 4'd8},
    '{OP_I, A_CTL, 32'h0, 32'd1, 4'd8},
    '{OP_R, A_STS, 32'h0, 32'h1, 4'd8},
    '{OP_W, A_STS, 32'h1, 32'h0, 4'd8},
    '{OP_R, A_STS, 32'h0, 32'h0, 4'd8},
    // R5 hit beats clear in the same cycle
    '{OP_W, A_MLO, 32'h3, 32'h0, 4'd5},
    '{OP_W, A_STS, 32'h1, 32'h0, 4'd5},
    '{OP_R, A_STS, 32'h0, 32'h1, 4'd5},
    '{OP_W, A_STS, 32'h1, 32'h0, 4'd5},
    '{OP_R, A_STS, 32'h0, 32'h0, 4'd5},
    // R4 running crossing, R8 no refire above compare
    '{OP_W, A_CTL, 32'h0, 32'h0, 4'd8},
    '{OP_W, A_CLO, 32'h0, 32'h0, 4'd8},
    '{OP_W, A_MLO, 32'h5, 32'h0, 4'd8},
    '{OP_W, A_CTL, 32'h3, 32'h0, 4'd4},
    '{OP_I, A_CTL, 32'h0, 32'd8, 4'd4},
    '{OP_R, A_STS, 32'h0, 32'h1, 4'd4},
    '{OP_W, A_STS, 32'h1, 32'h0, 4'd8},
    '{OP_I, A_CTL, 32'h0, 32'd4, 4'd8},
    '{OP_R, A_STS, 32'h0, 32'h0, 4'd8},
    '{OP_W, A_CTL, 32'h0, 32'h0, 4'd8},
    // R9 periodic reload
    '{OP_W, A_STP, 32'hA, 32'h0, 4'd9},
    '{OP_W, A_CLO, 32'h19, 32'h0, 4'd9},
    '{OP_W, A_MLO, 32'h14, 32'h0, 4'd9},
    '{OP_W, A_CTL, 32'hE, 32'h0, 4'd9},
    '{OP_I, A_CTL, 32'h0, 32'd1, 4'd9},
    '{OP_R, A_MLO, 32'h0, 32'h1E, 4'd9},
    '{OP_R, A_STS, 32'h0, 32'h1, 4'd9},
    '{OP_W, A_STS, 32'h1, 32'h0, 4'd9},
    '{OP_W, A_CLO, 32'h23, 32'h0, 4'd9},
    '{OP_I, A_CTL, 32'h0, 32'd1, 4'd9},
    '{OP_R, A_MLO, 32'h0, 32'h28, 4'd9},
    '{OP_R, A_STS, 32'h0, 32'h1, 4'd9},
    // R9 reload sum wraps modulo 2^64
    '{OP_W, A_CTL, 32'h0, 32'h0, 4'd9},
    '{OP_W, A_STS, 32'h1, 32'h0, 4'd9},
    '{OP_W, A_CLO, 32'hFFFFFFFF, 32'h0, 4'd9},
    '{OP_W, A_CHI, 32'hFFFFFFFF, 32'h0, 4'd9},
    '{OP_W, A_MLO, 32'hFFFFFFFB, 32'h0, 4'd9},
    '{OP_W, A_MHI, 32'hFFFFFFFF, 32'h0, 4'd9},
    '{OP_W, A_CTL, 32'hE, 32'h0, 4'd9},
    '{OP_W, A_CTL, 32'h0, 32'h0, 4'd9},
    '{OP_R, A_MLO, 32'h0, 32'h5, 4'd9},
    '{OP_R, A_MHI, 32'h0, 32'h0, 4'd9},
    // R6 set up a live interrupt before the reset test
    '{OP_W, A_CTL, 32'h6, 32'h0, 4'd6},
    '{OP_Q, A_CTL, 32'h0, 32'h1, 4'd6}
  };

  logic        clk;
  logic        rstN;
  logic        wrEn;
  logic [4:0]  addr;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        irqOut;

  int nChecks;
  int nFails;

  cmp_timer64 dut (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .irqOut (irqOut)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // All operations start and end in the low clock phase.
  task automatic doWrite(input logic [4:0] a, input logic [31:0] d);
    wrEn   = 1'b1;
    addr   = a;
    wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic doIdle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chkRead(input logic [4:0] a, input logic [31:0] e, input int r);
    addr = a;
    #0.5;
    nChecks++;
    if (rdData !== e) begin
      nFails++;
      $display("FAIL R%0d: read @%h got %h expected %h", r, a, rdData, e);
    end
  endtask

  task automatic chkIrq(input logic e, input int r);
    #0.5;
    nChecks++;
    if (irqOut !== e) begin
      nFails++;
      $display("FAIL R%0d: irqOut got %b expected %b", r, irqOut, e);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    nChecks = 0;
    nFails  = 0;
    rstN    = 1'b0;
    wrEn    = 1'b0;
    addr    = '0;
    wrData  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_W:    doWrite(VECS[i].adr, VECS[i].dat);
        OP_I:    doIdle(int'(VECS[i].exp));
        OP_R:    chkRead(VECS[i].adr, VECS[i].exp, int'(VECS[i].req));
        default: chkIrq(VECS[i].exp[0], int'(VECS[i].req));
      endcase
    end

    // R1 reset in the middle of operation returns everything to zero
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chkRead(A_CTL, 32'h0, 1);
    chkRead(A_STS, 32'h0, 1);
    chkRead(A_CLO, 32'h0, 1);
    chkRead(A_MHI, 32'h0, 1);
    chkIrq(1'b0, 1);

    // R10 wrap of the high word alone, after reset
    doWrite(A_CHI, 32'hFFFFFFFF);
    doWrite(A_CLO, 32'hFFFFFFFF);
    doWrite(A_CTL, 32'h1);
    doWrite(A_CTL, 32'h0);
    chkRead(A_CHI, 32'h0, 10);
    chkRead(A_CLO, 32'h0, 10);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule